// File: doc/BRIEF.md
# Banked Interrupt Controller

This block gathers up to 96 level-sensitive request lines into one interrupt request (IRQ) output and one fast interrupt (FIQ) output. The lines are split into three banks of 32. Each bank has a mask word that software can write directly. Software can also change single mask bits through two write-one aliases, one that sets bits and one that clears them. Each line also has a one-bit routing register. That bit steers the line either into IRQ arbitration or into the FIQ output.

Pending, unmasked, IRQ-routed lines go through a fixed-priority arbitration in which the lowest line number wins. The winning number is captured in a status word and the IRQ output is raised. Both stay frozen until software writes the acknowledge bit in the control word, which starts a new arbitration. The FIQ output is not latched. It follows the live OR of the pending, unmasked lines routed to FIQ.

Access is through a simple word-addressed 32-bit bus with a single-cycle write strobe and a combinational read port. The word address map is:

- control at 0x000
- status at 0x001
- for bank b: mask at 0x010+4b, set alias at 0x011+4b, clear alias at 0x012+4b
- routing for line n at 0x100+n

Top module: `intc_banked`

## Requirements
- R1: After a synchronous active-low reset, every mask bit reads 1, every routing bit reads 0, the status word reads 0, and both `irq_o` and `fiq_o` are low.
- R2: Line n is controlled by bit n%32 of the mask word of bank n/32 (word address 0x010+4·(n/32)). A mask bit of 1 disables the line. A write to that address replaces the whole mask word.
- R3: A write to the clear alias (0x012+4b) clears each mask bit whose data bit is 1 and leaves every other mask bit unchanged.
- R4: A write to the set alias (0x011+4b) sets each mask bit whose data bit is 1 and leaves every other mask bit unchanged.
- R5: While no vector is held, the next clock edge grants the lowest-numbered line that is high, unmasked and routed to IRQ. At that edge `irq_o` rises and the status word takes that line's number.
- R6: While a vector is held, `irq_o` stays high and the status word stays unchanged until an acknowledge. This holds even when lines drop, rise, or are re-masked or re-routed.
- R7: Writing bit 0 of the control word (0x000) releases the held vector and arbitrates again at the same edge. If no line qualifies, `irq_o` falls and the status word keeps its last value.
- R8: A routing register (0x100+n) with bit 0 set sends line n to `fiq_o` only. Such a line never wins IRQ arbitration.
- R9: `fiq_o` equals the OR of all lines that are high, unmasked and routed to FIQ, with no clock delay and no latching.
- R10: The status word carries the vector in bits 6:0, and its upper bits read 0. The control word, both aliases and unmapped addresses read 0. A routing register reads its bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 9 | Word address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_lines | input | 96 | Level-sensitive request lines, bit n is line n |
| irq_o | output | 1 | Latched IRQ request |
| fiq_o | output | 1 | Unlatched FIQ request |

## Verification
The directed part first raises lines while they are all masked, which shows that masking really blocks them. It then unmasks three lines in different banks one after another, so a lowest-number grant can be told apart from a first-come grant or a highest-number grant. A lower line is raised while a higher one is held, and a held line is dropped, which separates a frozen vector from one that is re-evaluated every cycle. Alias writes touch a single bit next to other bits that were cleared earlier, which exposes any read-modify-write that damages neighbouring bits. A held line is re-routed to FIQ before and after an acknowledge, which separates routing from masking. A long random phase then mixes line toggles, all three mask write forms, routing writes and acknowledges. In that phase the bench compares `irq_o`, `fiq_o` and the status word with its model on every clock.

// File: rtl/intc_pkg.sv
// Shared constants for the banked interrupt controller: the bus word
// address map, the bank register offsets and the control/routing bit
// positions. Assumes a 9-bit word address bus.
package intc_pkg;

    localparam int unsigned ADDR_W = 9;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL   = 9'h000;
    localparam logic [ADDR_W-1:0] A_STATUS = 9'h001;
    localparam logic [ADDR_W-1:0] A_BANK0  = 9'h010;
    localparam logic [ADDR_W-1:0] A_LEVEL0 = 9'h100;

    localparam int unsigned CTRL_ACK_BIT  = 0;
    localparam int unsigned LEVEL_FIQ_BIT = 0;

    // Offset of a register inside a four-word bank slot
    typedef enum logic [1:0] {
        BK_MASK = 2'd0,
        BK_SET  = 2'd1,
        BK_CLR  = 2'd2,
        BK_RSVD = 2'd3
    } bank_reg_e;

endpackage

// File: rtl/intc_mask_bank.sv
// One bank of mask bits. A 1 disables the corresponding line.
// Supports a direct word write and write-one set / clear aliases.
// Assumes at most one of the three write strobes is high per cycle
// (the decoder drives them from distinct addresses).
module intc_mask_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);

    // Mask word update: reset to all-disabled, then direct, set or clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (wr_mask) begin
            mask <= wdata;
        end else if (wr_set) begin
            mask <= mask | wdata;
        end else if (wr_clr) begin
            mask <= mask & ~wdata;
        end
    end

endmodule

// File: rtl/intc_route_table.sv
// Per-line routing bits. A 1 routes the line to the fast request output,
// a 0 to the arbitrated request output. One flop per line; the write
// index is the word offset from the routing base and is assumed to be
// range-checked by the caller.
module intc_route_table #(
    parameter int unsigned N     = 96,
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_fiq,
    output logic [N-1:0]     route
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic sel_fiq_q;

        // Routing bit for line i: reset to IRQ, loaded on an indexed write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_fiq_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                sel_fiq_q <= wr_fiq;
            end
        end

        assign route[i] = sel_fiq_q;
    end

endmodule

// File: rtl/intc_arbiter.sv
// Fixed-priority arbiter with a held vector. When idle, or when an
// acknowledge arrives, it loads the lowest-numbered qualifying request.
// Once loaded, the vector and busy flag are frozen until the next
// acknowledge. Assumes qual is already masked and routed by the caller.
module intc_arbiter #(
    parameter int unsigned N     = 96,
    parameter int unsigned VEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     qual,
    input  logic             ack,
    output logic             busy,
    output logic [VEC_W-1:0] vec
);

    logic             win_any;
    logic [VEC_W-1:0] win_idx;
    logic             load;

    // Priority encode: scanning downward leaves the lowest set index
    always_comb begin
        win_any = 1'b0;
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (qual[i]) begin
                win_any = 1'b1;
                win_idx = VEC_W'(i);
            end
        end
    end

    // Arbitration is open while nothing is held or on an acknowledge
    always_comb load = !busy || ack;

    // Held vector and request flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            vec  <= '0;
        end else if (load) begin
            busy <= win_any;
            if (win_any) begin
                vec <= win_idx;
            end
        end
    end

endmodule

// File: rtl/intc_banked.sv
// Banked interrupt controller top. Decodes the word-addressed register
// bus, instantiates one mask bank per group of BANK_W lines, the routing
// table and the arbiter, and drives the read mux and both request
// outputs. Assumes NUM_BANKS*BANK_W lines fit below the routing window
// end and that BANK_W equals the data width.
module intc_banked
    import intc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned BANK_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [intc_pkg::ADDR_W-1:0]       bus_addr,
    input  logic [intc_pkg::DATA_W-1:0]       bus_wdata,
    output logic [intc_pkg::DATA_W-1:0]       bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0]       irq_lines,
    output logic                              irq_o,
    output logic                              fiq_o
);

    localparam int unsigned N      = NUM_BANKS * BANK_W;
    localparam int unsigned VEC_W  = $clog2(N);
    localparam int unsigned SLOT_W = ADDR_W - 2;

    logic [N-1:0]         mask_all;
    logic [N-1:0]         route_all;
    logic [N-1:0]         qual_irq;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [ADDR_W-1:0]    lvl_off;
    logic                 lvl_hit;
    logic                 wr_ack;
    logic                 arb_busy;
    logic [VEC_W-1:0]     arb_vec;
    bank_reg_e            bank_reg;

    // Acknowledge strobe: control word write with the ack bit set
    always_comb wr_ack = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_ACK_BIT];

    // Register offset inside a bank slot
    always_comb bank_reg = bank_reg_e'(bus_addr[1:0]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] bank_mask;

        assign bank_hit[b] = (bus_addr[ADDR_W-1:2] == (A_BANK0[ADDR_W-1:2] + SLOT_W'(b)));

        intc_mask_bank #(
            .W (BANK_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_mask (bus_wr && bank_hit[b] && (bank_reg == BK_MASK)),
            .wr_set  (bus_wr && bank_hit[b] && (bank_reg == BK_SET)),
            .wr_clr  (bus_wr && bank_hit[b] && (bank_reg == BK_CLR)),
            .wdata   (bus_wdata[BANK_W-1:0]),
            .mask    (bank_mask)
        );

        assign mask_all[b*BANK_W +: BANK_W] = bank_mask;
    end

    // Routing window decode
    always_comb begin
        lvl_off = bus_addr - A_LEVEL0;
        lvl_hit = (bus_addr >= A_LEVEL0) && (lvl_off < ADDR_W'(N));
    end

    intc_route_table #(
        .N     (N),
        .IDX_W (ADDR_W)
    ) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr && lvl_hit),
        .wr_idx (lvl_off),
        .wr_fiq (bus_wdata[LEVEL_FIQ_BIT]),
        .route  (route_all)
    );

    // Requests eligible for IRQ arbitration
    always_comb qual_irq = irq_lines & ~mask_all & ~route_all;

    intc_arbiter #(
        .N     (N),
        .VEC_W (VEC_W)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .qual  (qual_irq),
        .ack   (wr_ack),
        .busy  (arb_busy),
        .vec   (arb_vec)
    );

    // Request outputs: held IRQ, live FIQ
    always_comb begin
        irq_o = arb_busy;
        fiq_o = |(irq_lines & ~mask_all & route_all);
    end

    // Read mux: status, mask words and routing bits; all else reads zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STATUS) begin
            bus_rdata[VEC_W-1:0] = arb_vec;
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b] && (bank_reg == BK_MASK)) begin
                bus_rdata[BANK_W-1:0] = mask_all[b*BANK_W +: BANK_W];
            end
        end
        for (int i = 0; i < N; i++) begin
            if (lvl_hit && (lvl_off == ADDR_W'(i))) begin
                bus_rdata[LEVEL_FIQ_BIT] = route_all[i];
            end
        end
    end

endmodule

// File: rtl/intc_banked_chk.sv
// Property checker for the banked interrupt controller, bound into the
// top module. Observes ports plus the mask, routing and vector state
// driven by the separate submodules.
module intc_banked_chk
    import intc_pkg::*;
#(
    parameter int unsigned N     = 96,
    parameter int unsigned W     = 32,
    parameter int unsigned VEC_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N-1:0]      irq_lines,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [N-1:0]      mask_all,
    input logic [N-1:0]      route_all,
    input logic [VEC_W-1:0]  arb_vec,
    input logic              ack
);

    logic [N-1:0] qual_c;
    logic [N-1:0] qual_q;
    logic [N-1:0] below_vec;

    // Eligible set seen by the checker, and its value one cycle back
    always_comb qual_c = irq_lines & ~mask_all & ~route_all;

    always_ff @(posedge clk) qual_q <= qual_c;

    // Lines numbered below the held vector
    always_comb below_vec = (N'(1) << arb_vec) - N'(1);

    // R1: reset drives masks to all ones and the request low
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && (&mask_all)));

    // R3: clear alias on bank 0 only clears the written ones
    assert_clear_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == (A_BANK0 + 9'd2)) |=>
        (mask_all[W-1:0] == ($past(mask_all[W-1:0]) & ~$past(bus_wdata[W-1:0]))));

    // R4: set alias on bank 0 only sets the written ones
    assert_set_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == (A_BANK0 + 9'd1)) |=>
        (mask_all[W-1:0] == ($past(mask_all[W-1:0]) | $past(bus_wdata[W-1:0]))));

    // R5: a fresh grant names an eligible line with none lower eligible
    assert_lowest_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (qual_q[arb_vec] && ((qual_q & below_vec) == '0)));

    // R6: a held vector is frozen until acknowledged
    assert_vector_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack) |=> (irq_o && $stable(arb_vec)));

    // R7: open arbitration raises the request exactly when a line qualifies
    assert_rearbitrate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o || ack) |=> (irq_o == (|qual_q)));

    // R9: with every line masked the fast request stays low
    assert_fiq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_all) |-> !fiq_o);

    // R10: status word upper bits always read zero
    assert_status_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STATUS) |-> (bus_rdata[DATA_W-1:VEC_W] == '0));

endmodule

bind intc_banked intc_banked_chk #(
    .N     (N),
    .W     (BANK_W),
    .VEC_W (VEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_lines (irq_lines),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .mask_all  (mask_all),
    .route_all (route_all),
    .arb_vec   (arb_vec),
    .ack       (wr_ack)
);

// File: tb/intc_banked_bench.sv
`timescale 1ns/1ps
// Bench for the banked interrupt controller: directed cases followed by
// a random phase, with a behavioural model compared on every clock.
module intc_banked_bench;

    localparam int NB = 3;
    localparam int W  = 32;
    localparam int N  = NB * W;

    localparam logic [8:0] AD_CTRL   = 9'h000;
    localparam logic [8:0] AD_STATUS = 9'h001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [8:0]    bus_addr = AD_STATUS;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_lines = '0;
    logic          irq_o;
    logic          fiq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural model state
    bit m_mask[N];
    bit m_route[N];
    bit m_busy;
    int m_vec;

    always #2.5 clk = ~clk;

    intc_banked u_intc_banked (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_lines),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    function automatic logic [8:0] bank_addr(int b, int off);
        return 9'(9'h010 + 4 * b + off);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each rising edge, using the inputs held since the last falling edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_mask[i] = 1'b1;
                m_route[i] = 1'b0;
            end
            m_busy = 1'b0;
            m_vec = 0;
        end else begin
            bit ack;
            ack = bus_wr && (bus_addr == AD_CTRL) && bus_wdata[0];
            if (!m_busy || ack) begin
                int pick;
                pick = -1;
                for (int i = 0; i < N; i++)
                    if (pick < 0 && irq_lines[i] && !m_mask[i] && !m_route[i]) pick = i;
                m_busy = (pick >= 0);
                if (pick >= 0) m_vec = pick;
            end
            if (bus_wr) begin
                int a;
                a = int'(bus_addr);
                if (a >= 16 && a < 16 + 4 * NB) begin
                    int b;
                    int r;
                    b = (a - 16) / 4;
                    r = (a - 16) % 4;
                    for (int j = 0; j < W; j++) begin
                        if (r == 0) m_mask[b*W+j] = bus_wdata[j];
                        else if (r == 1 && bus_wdata[j]) m_mask[b*W+j] = 1'b1;
                        else if (r == 2 && bus_wdata[j]) m_mask[b*W+j] = 1'b0;
                    end
                end
                if (a >= 256 && a < 256 + N) m_route[a-256] = bus_wdata[0];
            end
        end
    end

    // Every-clock comparison at the falling edge, before new inputs are driven
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_fiq;
            exp_fiq = 1'b0;
            for (int i = 0; i < N; i++)
                if (irq_lines[i] && !m_mask[i] && m_route[i]) exp_fiq = 1'b1;
            chk(irq_o == m_busy, "R5 R6 R7 irq_o vs model", 32'(irq_o), 32'(m_busy));
            chk(fiq_o == exp_fiq, "R8 R9 fiq_o vs model", 32'(fiq_o), 32'(exp_fiq));
            if (bus_addr == AD_STATUS && !bus_wr)
                chk(bus_rdata == 32'(m_vec), "R10 status vs model", bus_rdata, 32'(m_vec));
        end
    end

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_addr = AD_STATUS; bus_wdata = '0;
    endtask

    task automatic rd(logic [8:0] a, logic [31:0] exp, string tag);
        @(negedge clk); #1;
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
        bus_addr = AD_STATUS;
    endtask

    task automatic line(int i, bit v);
        @(negedge clk); #1;
        irq_lines[i] = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            done = 1;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1: reset state
        chk(irq_o == 1'b0 && fiq_o == 1'b0, "R1 outputs low", {30'd0, irq_o, fiq_o}, 32'd0);
        rd(AD_STATUS, 32'd0, "R1 status zero");
        rd(bank_addr(0, 0), 32'hFFFF_FFFF, "R1 bank0 mask");
        rd(bank_addr(2, 0), 32'hFFFF_FFFF, "R1 bank2 mask");
        rd(9'h100 + 9'd7, 32'd0, "R1 route line7");

        // R2: masked lines do nothing
        line(3, 1); line(40, 1); line(70, 1);
        idle(3);
        chk(irq_o == 1'b0, "R2 masked lines ignored", 32'(irq_o), 32'd0);

        // R3 + R2 mapping: unmask line 40 (bank1 bit8) and 70 (bank2 bit6)
        wr(bank_addr(1, 2), 32'h0000_0100);
        wr(bank_addr(2, 2), 32'h0000_0040);
        idle(1);
        rd(AD_STATUS, 32'd40, "R5 lowest of 40,70");
        rd(bank_addr(1, 0), 32'hFFFF_FEFF, "R3 clear alias bank1");
        chk(irq_o == 1'b1, "R5 irq raised", 32'(irq_o), 32'd1);

        // R6: lower line enabled while 40 is held
        wr(bank_addr(0, 2), 32'h0000_00F8);
        idle(2);
        rd(AD_STATUS, 32'd40, "R6 vector frozen");
        rd(bank_addr(0, 0), 32'hFFFF_FF07, "R3 clear alias bank0");

        // R7: acknowledge picks line 3
        wr(AD_CTRL, 32'd1);
        rd(AD_STATUS, 32'd3, "R7 rearbitrated to 3");

        // R6: dropping the held line keeps it held
        line(3, 0);
        idle(2);
        chk(irq_o == 1'b1, "R6 held after line drop", 32'(irq_o), 32'd1);
        rd(AD_STATUS, 32'd3, "R6 vector kept after drop");

        // R4: set alias touches only written bits
        wr(bank_addr(0, 1), 32'h0000_0010);
        rd(bank_addr(0, 0), 32'hFFFF_FF17, "R4 set alias bank0");
        wr(bank_addr(1, 1), 32'h0000_0100);
        rd(bank_addr(1, 0), 32'hFFFF_FFFF, "R4 set alias bank1");

        // R7: ack with 3 low, 40 masked -> 70
        wr(AD_CTRL, 32'd1);
        rd(AD_STATUS, 32'd70, "R7 next is 70");

        // R8: route 70 to FIQ while held
        wr(9'h100 + 9'd70, 32'd1);
        rd(9'h100 + 9'd70, 32'd1, "R10 route readback");
        chk(fiq_o == 1'b1, "R8 fiq raised", 32'(fiq_o), 32'd1);
        chk(irq_o == 1'b1, "R6 irq held across reroute", 32'(irq_o), 32'd1);
        wr(AD_CTRL, 32'd1);
        idle(1);
        chk(irq_o == 1'b0, "R8 fiq line not in irq arbitration", 32'(irq_o), 32'd0);
        rd(AD_STATUS, 32'd70, "R7 status kept when idle");

        // R9: fiq follows the line without latching
        @(negedge clk); #1 irq_lines[70] = 1'b0; #1;
        chk(fiq_o == 1'b0, "R9 fiq drops combinationally", 32'(fiq_o), 32'd0);
        @(negedge clk); #1 irq_lines[70] = 1'b1; #1;
        chk(fiq_o == 1'b1, "R9 fiq rises combinationally", 32'(fiq_o), 32'd1);

        // R2: direct mask write disables the line
        wr(bank_addr(2, 0), 32'hFFFF_FFFF);
        #1;
        chk(fiq_o == 1'b0, "R2 direct mask write", 32'(fiq_o), 32'd0);

        // R10: zero reads
        rd(AD_CTRL, 32'd0, "R10 ctrl reads zero");
        rd(bank_addr(0, 1), 32'd0, "R10 set alias reads zero");
        rd(bank_addr(1, 2), 32'd0, "R10 clear alias reads zero");
        rd(9'h0FF, 32'd0, "R10 unmapped reads zero");

        // Random phase against the model
        for (int k = 0; k < 4000; k++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op <= 3) begin
                line($urandom_range(0, N - 1), 1'($urandom_range(0, 1)));
            end else if (op == 4) begin
                wr(bank_addr($urandom_range(0, NB - 1), 2), $urandom);
            end else if (op == 5) begin
                wr(bank_addr($urandom_range(0, NB - 1), 1), $urandom & $urandom);
            end else if (op == 6) begin
                wr(bank_addr($urandom_range(0, NB - 1), 0), $urandom);
            end else if (op == 7) begin
                wr(9'(9'h100 + $urandom_range(0, N - 1)), 32'($urandom_range(0, 3) == 0));
            end else begin
                wr(AD_CTRL, 32'd1);
            end
        end

        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule